// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits between a set of interrupt sources and a CPU core. Each maskable source presents a level-sensitive request. It also carries an enable bit and a one-bit control level. Two further inputs come from outside that set: a non-maskable request and an address-break request. The CPU supplies its global mask bit, a user mask bit and a two-bit control-mode field. The block gates the requests through these masks and groups the maskable ones by control level. It then applies a fixed priority order, registers the single winner, and raises an interrupt flag to the CPU together with a vector number.

The winner and its vector stay frozen from the moment the flag rises until the CPU acknowledges with a one-cycle pulse. In the cycle after that pulse the block asserts a one-cycle strobe that tells the CPU to set its global mask. In three-level mode it also asserts a strobe for the user mask. The block then waits one settle cycle before it arbitrates again, so the newly set mask takes effect. No request is cleared by the block. A source that was not served stays pending until its own request or enable drops.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irqOut, setMask and setUserMask are 0 and vecOut is 0.
- R2: A maskable source whose enable bit is 0 is never accepted; with no accepted candidate irqOut stays 0.
- R3: When the global mask is 0, an enabled request with control level 1 wins over any enabled request with control level 0, whatever their indices.
- R4: Among enabled maskable requests at the same control level, the lowest index wins and vecOut = SRC_BASE + index.
- R5: The non-maskable request wins over address-break, and address-break wins over every maskable source. Their vectors are NMI_VEC and BRK_VEC. Neither is affected by the enable bits, the control levels, the global mask or the user mask.
- R6: While ccrMask is 1, no maskable source is accepted. It stays pending and is accepted once ccrMask returns to 0 while it is still asserted.
- R7: With modeSel = 2'b10 (three-level mode), ccrMask = 0 and ccrUser = 1, only control-level-1 maskable sources are accepted. For any other modeSel value, ccrUser has no effect.
- R8: From the cycle irqOut rises until the acknowledge, irqOut stays 1 and vecOut stays unchanged, whatever the requests do.
- R9: A cpuAck sampled while irqOut is 1 makes irqOut 0, vecOut 0 and setMask 1 for exactly the following cycle. setUserMask is 1 in that cycle only if modeSel was 2'b10 at the acknowledge.
- R10: A candidate present at a clock edge while the block is idle makes irqOut rise at that edge. The cycle after a setMask pulse never starts a new acceptance.
- R11: cpuAck while irqOut is 0 has no effect: setMask stays 0.
- R12: A maskable request that drops while pending is not served later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcReq | input | NUM_SRC | Maskable source requests, level-sensitive |
| srcEn | input | NUM_SRC | Per-source enable bits |
| srcLvl | input | NUM_SRC | Per-source control level, 1 = upper group |
| nmiReq | input | 1 | Non-maskable request |
| brkReq | input | 1 | Address-break request |
| ccrMask | input | 1 | CPU global mask bit |
| ccrUser | input | 1 | CPU user mask bit |
| modeSel | input | 2 | Control mode; 2'b10 selects three-level mode |
| cpuAck | input | 1 | One-cycle acknowledge from the CPU |
| irqOut | output | 1 | Interrupt request to the CPU |
| vecOut | output | VEC_W | Vector number of the held winner |
| setMask | output | 1 | Strobe telling the CPU to set its global mask |
| setUserMask | output | 1 | Strobe telling the CPU to set its user mask |

## Verification
Two functions can meet at one clock edge. One is the hold of a registered winner. The other is the arrival of a stronger request, such as the non-maskable one or a level-1 source. The bench provokes this by latching a low-priority source and then, during the hold, dropping it and raising higher-priority requests. It judges the result by checking that the vector does not move until the acknowledge. A second meeting point is the acknowledge cycle and a waiting candidate. The bench checks that the settle cycle accepts nothing, and that the candidate is taken only after the mask strobe, under the mask value the CPU then presents.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam logic [1:0] THREE_LVL_MODE = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SETTLE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic loadWin;
    logic clrWin;
  } winStrobe_t;

endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcLvl,
  input  logic               ccrMask,
  input  logic               ccrUser,
  input  logic [1:0]         modeSel,
  output logic [NUM_SRC-1:0] hiReq,
  output logic [NUM_SRC-1:0] loReq
);
  import irq_pkg::*;

  logic threeLvl;
  logic loBlocked;

  assign threeLvl  = (modeSel == THREE_LVL_MODE);
  assign loBlocked = ccrMask | (threeLvl & ccrUser);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic live;
    assign live     = srcReq[i] & srcEn[i];
    assign hiReq[i] = live &  srcLvl[i] & ~ccrMask;
    assign loReq[i] = live & ~srcLvl[i] & ~loBlocked;
  end

endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NUM_SRC  = 16,
  parameter int VEC_W    = 8,
  parameter int SRC_BASE = 32,
  parameter int NMI_VEC  = 7,
  parameter int BRK_VEC  = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                nmiReq,
  input  logic                brkReq,
  input  logic [NUM_SRC-1:0]  hiReq,
  input  logic [NUM_SRC-1:0]  loReq,
  input  irq_pkg::winStrobe_t strobe,
  output logic                anyCand,
  output logic [VEC_W-1:0]    vecOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0] hiIdx, loIdx;
  logic             hiAny, loAny;
  logic [VEC_W-1:0] winVec;
  logic [VEC_W-1:0] vecReg;

  always_comb begin
    hiIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hiReq[i]) hiIdx = IDX_W'(i);
    end
  end

  always_comb begin
    loIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (loReq[i]) loIdx = IDX_W'(i);
    end
  end

  assign hiAny   = |hiReq;
  assign loAny   = |loReq;
  assign anyCand = nmiReq | brkReq | hiAny | loAny;

  always_comb begin
    if (nmiReq)      winVec = VEC_W'(NMI_VEC);
    else if (brkReq) winVec = VEC_W'(BRK_VEC);
    else if (hiAny)  winVec = VEC_W'(SRC_BASE) + VEC_W'(hiIdx);
    else             winVec = VEC_W'(SRC_BASE) + VEC_W'(loIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               vecReg <= '0;
    else if (strobe.clrWin)  vecReg <= '0;
    else if (strobe.loadWin) vecReg <= winVec;
  end

  assign vecOut = vecReg;

  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWin && nmiReq) |=> (vecOut == VEC_W'(NMI_VEC)));

  a_r5_brk_second: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWin && !nmiReq && brkReq) |=> (vecOut == VEC_W'(BRK_VEC)));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                anyCand,
  input  logic                cpuAck,
  input  logic                threeLvl,
  output irq_pkg::winStrobe_t strobe,
  output logic                irqOut,
  output logic                setMask,
  output logic                setUserMask
);
  import irq_pkg::*;

  ctrlState_t state, stateNxt;
  logic       userAtAck;

  always_comb begin
    stateNxt       = state;
    strobe.loadWin = 1'b0;
    strobe.clrWin  = 1'b0;
    case (state)
      ST_IDLE: if (anyCand) begin
        stateNxt       = ST_HOLD;
        strobe.loadWin = 1'b1;
      end
      ST_HOLD: if (cpuAck) begin
        stateNxt      = ST_SETTLE;
        strobe.clrWin = 1'b1;
      end
      ST_SETTLE: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      userAtAck <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.clrWin) userAtAck <= threeLvl;
    end
  end

  assign irqOut      = (state == ST_HOLD);
  assign setMask     = (state == ST_SETTLE);
  assign setUserMask = (state == ST_SETTLE) && userAtAck;

  a_r9_mask_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && cpuAck) |=> (setMask && !irqOut));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    setMask |=> !setMask);

  a_r10_settle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    setMask |=> !irqOut);

  a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !anyCand && cpuAck) |=> (!setMask && !irqOut));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC  = 16,
  parameter int VEC_W    = 8,
  parameter int SRC_BASE = 32,
  parameter int NMI_VEC  = 7,
  parameter int BRK_VEC  = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcLvl,
  input  logic               nmiReq,
  input  logic               brkReq,
  input  logic               ccrMask,
  input  logic               ccrUser,
  input  logic [1:0]         modeSel,
  input  logic               cpuAck,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic               setMask,
  output logic               setUserMask
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] hiReq, loReq;
  logic               anyCand;
  winStrobe_t         strobe;

  irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .srcReq (srcReq),
    .srcEn  (srcEn),
    .srcLvl (srcLvl),
    .ccrMask(ccrMask),
    .ccrUser(ccrUser),
    .modeSel(modeSel),
    .hiReq  (hiReq),
    .loReq  (loReq)
  );

  irq_arb #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .SRC_BASE(SRC_BASE),
    .NMI_VEC (NMI_VEC),
    .BRK_VEC (BRK_VEC)
  ) u_arb (
    .clk    (clk),
    .rstN   (rstN),
    .nmiReq (nmiReq),
    .brkReq (brkReq),
    .hiReq  (hiReq),
    .loReq  (loReq),
    .strobe (strobe),
    .anyCand(anyCand),
    .vecOut (vecOut)
  );

  irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyCand    (anyCand),
    .cpuAck     (cpuAck),
    .threeLvl   (modeSel == THREE_LVL_MODE),
    .strobe     (strobe),
    .irqOut     (irqOut),
    .setMask    (setMask),
    .setUserMask(setUserMask)
  );

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !cpuAck) |=> (irqOut && $stable(vecOut)));

  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWin && ccrMask) |-> (nmiReq || brkReq));

  a_r10_rise_needs_cand: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(anyCand));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int VW   = 8;
  localparam int BASE = 32;
  localparam int NMIV = 7;
  localparam int BRKV = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcReq = '0, srcEn = '0, srcLvl = '0;
  logic nmiReq = 1'b0, brkReq = 1'b0, ccrMask = 1'b0, ccrUser = 1'b0, cpuAck = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic irqOut, setMask, setUserMask;
  logic [VW-1:0] vecOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS), .VEC_W(VW), .SRC_BASE(BASE), .NMI_VEC(NMIV), .BRK_VEC(BRKV))
  u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn), .srcLvl(srcLvl),
    .nmiReq(nmiReq), .brkReq(brkReq), .ccrMask(ccrMask), .ccrUser(ccrUser),
    .modeSel(modeSel), .cpuAck(cpuAck), .irqOut(irqOut), .vecOut(vecOut),
    .setMask(setMask), .setUserMask(setUserMask)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Expected acceptance from the requirements: returns -1 when nothing is accepted.
  function automatic int model();
    logic [NS-1:0] live;
    bit three;
    live  = srcReq & srcEn;
    three = (modeSel == 2'b10);
    if (nmiReq) return NMIV;
    if (brkReq) return BRKV;
    if (ccrMask) return -1;
    for (int i = 0; i < NS; i++) if (live[i] && srcLvl[i]) return BASE + i;
    if (three && ccrUser) return -1;
    for (int i = 0; i < NS; i++) if (live[i] && !srcLvl[i]) return BASE + i;
    return -1;
  endfunction

  // Inputs already driven at a falling edge; arbitrate, check, and acknowledge.
  task automatic arbOnce(input string tag);
    int exp;
    bit expUser;
    exp = model();
    expUser = (modeSel == 2'b10);
    @(posedge clk); @(negedge clk);
    if (exp < 0) begin
      chk({tag, " idle irqOut"}, int'(irqOut), 0);
    end else begin
      chk({tag, " irqOut"}, int'(irqOut), 1);
      chk({tag, " vecOut"}, int'(vecOut), exp);
      cpuAck = 1'b1;
      @(negedge clk);
      cpuAck = 1'b0;
      chk("R9 setMask", int'(setMask), 1);
      chk("R9 irqOut low", int'(irqOut), 0);
      chk("R9 vec cleared", int'(vecOut), 0);
      chk("R9 setUserMask", int'(setUserMask), int'(expUser));
      @(negedge clk);
      chk("R9 single pulse", int'(setMask), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R1 watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irqOut", int'(irqOut), 0);
    chk("R1 vecOut", int'(vecOut), 0);
    chk("R1 setMask", int'(setMask), 0);
    chk("R1 setUserMask", int'(setUserMask), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Exhaustive two-level sweep: R2 (enable), R3 (level grouping), R4 (order).
    for (int e = 0; e < 16; e++)
      for (int l = 0; l < 16; l++)
        for (int r = 0; r < 16; r++) begin
          logic [NS-1:0] lv;
          srcEn = NS'(e); srcLvl = NS'(l); srcReq = NS'(r);
          lv = srcReq & srcEn;
          if (lv == '0) arbOnce("R2");
          else if ((lv & srcLvl) != '0 && (lv & ~srcLvl) != '0) arbOnce("R3");
          else arbOnce("R4");
        end

    // R5: nmi / break against all maskable patterns, with the global mask set and clear.
    srcEn = '1;
    for (int m = 0; m < 2; m++)
      for (int nb = 1; nb < 4; nb++)
        for (int r = 0; r < 16; r++) begin
          ccrMask = m[0]; nmiReq = nb[0]; brkReq = nb[1];
          srcReq = NS'(r); srcLvl = NS'(r ^ 5);
          arbOnce("R5");
        end
    nmiReq = 1'b0; brkReq = 1'b0; ccrMask = 1'b0;

    // R7: three-level mode with user mask, and other modes ignoring ccrUser.
    for (int md = 0; md < 4; md++)
      for (int u = 0; u < 2; u++)
        for (int l = 0; l < 16; l++)
          for (int r = 0; r < 16; r++) begin
            modeSel = 2'(md); ccrUser = u[0]; srcLvl = NS'(l); srcReq = NS'(r);
            arbOnce("R7");
          end
    modeSel = 2'b00; ccrUser = 1'b0;

    // R6: pending under the global mask, break passes, pending served after clear.
    srcReq = '0; srcLvl = '0; srcEn = '1;
    @(negedge clk);
    ccrMask = 1'b1; srcReq = 4'b0100;
    arbOnce("R6");
    brkReq = 1'b1;
    arbOnce("R6");
    brkReq = 1'b0;
    arbOnce("R6");
    @(negedge clk);
    chk("R6 still pending", int'(irqOut), 0);
    ccrMask = 1'b0;
    arbOnce("R6");
    srcReq = '0;

    // R12: a request dropped while masked is not served later.
    @(negedge clk);
    ccrMask = 1'b1; srcReq = 4'b0010;
    @(negedge clk);
    srcReq = '0;
    @(negedge clk);
    ccrMask = 1'b0;
    @(negedge clk);
    chk("R12 no late service", int'(irqOut), 0);
    @(negedge clk);
    chk("R12 no late service 2", int'(irqOut), 0);

    // R10: latency of exactly one edge; R8: hold against stronger arrivals.
    srcReq = 4'b0100; srcLvl = '0;
    chk("R10 not before edge", int'(irqOut), 0);
    @(negedge clk);
    chk("R10 rises at edge", int'(irqOut), 1);
    srcReq = 4'b0001; srcLvl = 4'b0001; nmiReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 irq held", int'(irqOut), 1);
      chk("R8 vec held", int'(vecOut), BASE + 2);
    end
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    chk("R9 setMask after hold", int'(setMask), 1);
    // Candidates (nmi) present through the settle cycle: nothing accepted there.
    @(negedge clk);
    chk("R10 settle accepts nothing", int'(irqOut), 0);
    @(negedge clk);
    chk("R10 accepted after settle", int'(irqOut), 1);
    chk("R5 nmi vector", int'(vecOut), NMIV);
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    nmiReq = 1'b0; srcReq = '0;
    @(negedge clk);

    // R11: ack with nothing pending.
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    chk("R11 setMask", int'(setMask), 0);
    chk("R11 irqOut", int'(irqOut), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule